// File: doc/BRIEF.md
# Synchronized Serial Synthesizer Programming Port

This block is the programming port of a fractional-N synthesizer's control section. Software writes it over three wires: a serial clock, a serial data line and a latch line. While the latch line is low, every rising serial-clock edge shifts one data bit in. When the latch line rises, shifting stops and the assembled 24-bit word is decoded by its two leading bits. A control word takes effect at once. A fractional-compensation word is only parked in a temporary register. A divider word is held until the divider's terminal-count sync pulse arrives.

The divider word moves into the working divider register only when the sync pulse is sampled while the latch line is still high. The parked fractional data moves into its working register in the same clock cycle, so the divider ratio and its fractional correction never change mid-cycle or separately. After that commit, a speed-up flag for the charge pump stays high until the latch line falls. All three serial lines are resynchronized into the system clock domain. The sync pulse already belongs to that domain.

Top module: `synth_prog_port`

## Requirements
- R1: While the latch line is low, each rising serial-clock edge shifts the data bit into a 24-bit register. The first bit sent ends up as bit 23. Only the last 24 bits before the latch rises form the word.
- R2: While the latch line is high, serial-clock edges and data changes have no effect on the word being assembled.
- R3: On the latch rising edge, bits [23:22] select the word type: 00 divider, 01 fractional compensation, 10 control. Code 11 is ignored and changes no output. The payload is bits [21:0].
- R4: A control word's payload appears on `ctrl_word` right after the latch rising edge, with no sync pulse needed.
- R5: A fractional-compensation word goes only to a temporary register. `frac_comp` is unchanged until a later divider-word commit.
- R6: A pending divider word commits on the first clock in which `div_sync` is high while the latch line is high. `div_ratio` takes the divider payload and `frac_comp` takes the temporary fractional data in that same cycle.
- R7: If no sync pulse occurs while the latch line is high, the divider word is discarded when the latch falls. A later sync pulse does not commit it.
- R8: `speedup` rises in the commit cycle, stays high while the latch line remains high, and is low once the latch line is low.
- R9: Synchronous reset clears the shift, temporary and working registers, the pending state and `speedup`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, first bit sent becomes bit 23 |
| ser_latch | input | 1 | Latch line: low shifts, rising stores the word |
| div_sync | input | 1 | Divider terminal-count pulse, clk domain |
| div_ratio | output | 22 | Working divider ratio |
| frac_comp | output | 22 | Working fractional-compensation data |
| ctrl_word | output | 22 | Working control word |
| speedup | output | 1 | Charge-pump speed-up flag |

## Verification
A table of words exercises every address code in a chosen order. The order is picked to tell apart a fractional word parked in the temporary register from one applied early, a divider word committed by a sync pulse from one left waiting, and an ignored code from a decoded one. Some divider words get a sync pulse while latched and some get none, so a commit that skips the sync qualification shows up as a wrong `div_ratio`. Directed cases send extra serial clocks while latched, send a sync pulse only after the latch falls, hold the latch high for a long time to watch `speedup`, send over-long frames, and reset mid-run.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DIV  = 2'b00,
        ADR_FRAC = 2'b01,
        ADR_CTRL = 2'b10,
        ADR_NONE = 2'b11
    } addr_e;

    typedef struct packed {
        addr_e            addr;
        logic [PAY_W-1:0] payload;
    } prog_word_t;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } latch_ev_t;

    function automatic logic is_known(input addr_e a);
        return a != ADR_NONE;
    endfunction

endpackage

// File: rtl/prog_in_sync.sv
module prog_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/prog_shift.sv
module prog_shift
    import synth_prog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_rise,
    input  logic       latch_lvl,
    input  logic       bit_in,
    output prog_word_t word
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (sclk_rise && !latch_lvl)
            sh_q <= {sh_q[WORD_W-2:0], bit_in};
    end

    assign word = prog_word_t'(sh_q);

    // R2: no shifting while the latch line is high
    a_r2_hold_when_latched: assert property (@(posedge clk) disable iff (rst)
        latch_lvl |=> $stable(sh_q));
endmodule

// File: rtl/prog_regs.sv
module prog_regs
    import synth_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  prog_word_t       word,
    input  latch_ev_t        latch,
    input  logic             div_sync,
    output logic [PAY_W-1:0] div_ratio,
    output logic [PAY_W-1:0] frac_comp,
    output logic [PAY_W-1:0] ctrl_word,
    output logic             speedup
);
    logic [PAY_W-1:0] div_hold_q;
    logic [PAY_W-1:0] frac_temp_q;
    logic [PAY_W-1:0] div_q, frac_q, ctrl_q;
    logic             pending_q, speedup_q;
    logic             commit;

    assign commit = pending_q && latch.lvl && div_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_hold_q  <= '0;
            frac_temp_q <= '0;
            div_q       <= '0;
            frac_q      <= '0;
            ctrl_q      <= '0;
            pending_q   <= 1'b0;
            speedup_q   <= 1'b0;
        end else begin
            if (latch.rise && is_known(word.addr)) begin
                case (word.addr)
                    ADR_DIV: begin
                        div_hold_q <= word.payload;
                        pending_q  <= 1'b1;
                    end
                    ADR_FRAC: frac_temp_q <= word.payload;
                    ADR_CTRL: ctrl_q      <= word.payload;
                    default: ;
                endcase
            end
            if (commit) begin
                div_q     <= div_hold_q;
                frac_q    <= frac_temp_q;
                pending_q <= 1'b0;
                speedup_q <= 1'b1;
            end
            if (latch.fall) begin
                pending_q <= 1'b0;
                speedup_q <= 1'b0;
            end
        end
    end

    assign div_ratio = div_q;
    assign frac_comp = frac_q;
    assign ctrl_word = ctrl_q;
    assign speedup   = speedup_q;

    // R6: the divider register moves only on a sync pulse seen while latched
    a_r6_commit_on_sync: assert property (@(posedge clk) disable iff (rst)
        (div_q != $past(div_q)) |-> ($past(div_sync) && $past(latch.lvl)));

    // R5: fractional data reaches its working register only with a commit
    a_r5_frac_with_div: assert property (@(posedge clk) disable iff (rst)
        (frac_q != $past(frac_q)) |-> $rose(speedup_q));

    // R8: speed-up is low after any cycle with the latch line low
    a_r8_speedup_low: assert property (@(posedge clk) disable iff (rst)
        !latch.lvl |=> !speedup_q);

    // R4: the control register changes only on a latch rising edge
    a_r4_ctrl_on_rise: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q != $past(ctrl_q)) |-> $past(latch.rise));
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_latch,
    input  logic             div_sync,
    output logic [PAY_W-1:0] div_ratio,
    output logic [PAY_W-1:0] frac_comp,
    output logic [PAY_W-1:0] ctrl_word,
    output logic             speedup
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] lines_s;
    logic              sclk_prev, latch_prev;
    logic              sclk_rise;
    latch_ev_t         latch;
    prog_word_t        word;

    prog_in_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_latch, ser_data, ser_clk}),
        .dout (lines_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev  <= 1'b0;
            latch_prev <= 1'b0;
        end else begin
            sclk_prev  <= lines_s[0];
            latch_prev <= lines_s[2];
        end
    end

    assign sclk_rise  = lines_s[0] & ~sclk_prev;
    assign latch.lvl  = lines_s[2];
    assign latch.rise = lines_s[2] & ~latch_prev;
    assign latch.fall = ~lines_s[2] & latch_prev;

    prog_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .latch_lvl (latch.lvl),
        .bit_in    (lines_s[1]),
        .word      (word)
    );

    prog_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .word      (word),
        .latch     (latch),
        .div_sync  (div_sync),
        .div_ratio (div_ratio),
        .frac_comp (frac_comp),
        .ctrl_word (ctrl_word),
        .speedup   (speedup)
    );
endmodule

// File: tb/test_synth_prog_port.sv
`timescale 1ns/1ps
module test_synth_prog_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0, div_sync = 1'b0;
    logic [21:0] div_ratio, frac_comp, ctrl_word;
    logic        speedup;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    synth_prog_port i_synth_prog_port (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .div_sync(div_sync), .div_ratio(div_ratio),
        .frac_comp(frac_comp), .ctrl_word(ctrl_word), .speedup(speedup)
    );

    typedef struct packed {
        logic [23:0] word;
        logic        sync;
        logic [21:0] e_div;
        logic [21:0] e_frac;
        logic [21:0] e_ctrl;
        logic        e_sp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{24'h95A5A5, 1'b0, 22'h000000, 22'h000000, 22'h15A5A5, 1'b0}, // R4 control
        '{24'h400ABC, 1'b0, 22'h000000, 22'h000000, 22'h15A5A5, 1'b0}, // R5 parked
        '{24'h012345, 1'b1, 22'h012345, 22'h000ABC, 22'h15A5A5, 1'b1}, // R6 commit
        '{24'h400123, 1'b0, 22'h012345, 22'h000ABC, 22'h15A5A5, 1'b0}, // R5 parked
        '{24'h2AAAAA, 1'b0, 22'h012345, 22'h000ABC, 22'h15A5A5, 1'b0}, // R7 no sync
        '{24'hFFFFFF, 1'b1, 22'h012345, 22'h000ABC, 22'h15A5A5, 1'b0}, // R3 code 11
        '{24'h000777, 1'b1, 22'h000777, 22'h000123, 22'h15A5A5, 1'b1}, // R6 commit
        '{24'h800003, 1'b0, 22'h000777, 22'h000123, 22'h000003, 1'b0}  // R4 control
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        cycles(3);
        ser_clk = 1'b1;
        cycles(3);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
        cycles(2);
    endtask

    task automatic latch_up;
        ser_latch = 1'b1;
        cycles(6);
    endtask

    task automatic latch_down;
        ser_latch = 1'b0;
        cycles(6);
    endtask

    task automatic sync_pulse;
        div_sync = 1'b1;
        cycles(1);
        div_sync = 1'b0;
        cycles(2);
    endtask

    initial begin
        cycles(5);
        rst = 1'b0;
        cycles(2);
        // R9 reset state
        check("R9 div after reset", 32'(div_ratio), 32'h0);
        check("R9 frac after reset", 32'(frac_comp), 32'h0);
        check("R9 ctrl after reset", 32'(ctrl_word), 32'h0);
        check("R9 speedup after reset", 32'(speedup), 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            send_word(VEC[v].word);
            latch_up();
            if (VEC[v].sync) sync_pulse();
            check($sformatf("R3/R6 vec%0d div", v), 32'(div_ratio), 32'(VEC[v].e_div));
            check($sformatf("R5/R6 vec%0d frac", v), 32'(frac_comp), 32'(VEC[v].e_frac));
            check($sformatf("R4 vec%0d ctrl", v), 32'(ctrl_word), 32'(VEC[v].e_ctrl));
            check($sformatf("R8 vec%0d speedup high", v), 32'(speedup), 32'(VEC[v].e_sp));
            latch_down();
            check($sformatf("R8 vec%0d speedup low", v), 32'(speedup), 32'h0);
        end

        // R2: serial clocks while latched are ignored
        send_word(24'h0000AA);
        latch_up();
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        sync_pulse();
        check("R2 word kept while latched", 32'(div_ratio), 32'h0000AA);
        latch_down();

        // R7: sync pulse after latch falls does not commit
        send_word(24'h000055);
        latch_up();
        latch_down();
        sync_pulse();
        check("R7 late sync no commit", 32'(div_ratio), 32'h0000AA);
        check("R7 late sync no speedup", 32'(speedup), 32'h0);

        // R8: speed-up held for a long latch-high period
        send_word(24'h000099);
        latch_up();
        check("R8 speedup low before sync", 32'(speedup), 32'h0);
        sync_pulse();
        check("R8 speedup at commit", 32'(speedup), 32'h1);
        cycles(40);
        check("R8 speedup held", 32'(speedup), 32'h1);
        check("R6 div at commit", 32'(div_ratio), 32'h000099);
        latch_down();
        check("R8 speedup dropped", 32'(speedup), 32'h0);

        // R1: over-long frame, only the last 24 bits count
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        send_word(24'h800042);
        latch_up();
        check("R1 last 24 bits kept", 32'(ctrl_word), 32'h000042);
        latch_down();

        // R9: reset mid-run clears everything, including parked data
        send_word(24'h400777);
        latch_up();
        latch_down();
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
        cycles(2);
        check("R9 div cleared", 32'(div_ratio), 32'h0);
        check("R9 ctrl cleared", 32'(ctrl_word), 32'h0);
        send_word(24'h000011);
        latch_up();
        sync_pulse();
        check("R9 temp frac cleared", 32'(frac_comp), 32'h0);
        check("R9 div after reset commit", 32'(div_ratio), 32'h000011);
        latch_down();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule